// File: doc/BRIEF.md
# Command Stream Firewall Validator

This block checks a stream of 32-bit command words before a host command processor may run it. Each header word is decoded into an opcode, a target register, and either a count or a mask. The block then follows the payload words that belong to that header and works out which register each payload word writes. A payload word that lands on an address-type register must match the next entry of an ordered relocation list. Otherwise the job is rejected.

A job opens with a `job_start` pulse. That pulse latches the job's class and empties the relocation list. Relocation descriptors (buffer id, byte offset, shift) are then appended in order. Command words arrive one per cycle. Each gather is framed by a start flag and an end flag, and each gather carries the id of its buffer. The last word of the job carries the job-end flag.

A small programmable table holds up to 16 (class, register) pairs. It decides which registers are address registers. When the job ends, `pass` or `fail` reports the verdict and holds until the next `job_start`.

Top module: `cmdfw_check`

## Requirements
- R1: After reset, `pass` and `fail` are 0 and `in_ready` is 1.
- R2: The opcode is in word bits 31:28. Opcode 0 loads the current class from bits 15:6 and a 6-bit mask from bits 5:0, with the register base in bits 27:16. The class must equal `job_class` as latched at `job_start`. When `cls_rng_en` is 1, the class must instead lie within `cls_lo`..`cls_hi`. Otherwise the job fails. The mask is walked as in R5.
- R3: Opcode 1 takes a count from bits 15:0. Payload word k (counting from 0) targets register base+k.
- R4: Opcode 2 takes a count from bits 15:0. Every payload word targets the base register.
- R5: Opcode 3 takes a mask from bits 15:0, scanned from bit 0 upward. Each set bit at position b consumes one payload word for register base+b. Clear bits consume no word.
- R6: Opcodes 4 and 14 have no payload and are accepted. Any opcode other than 0, 1, 2, 3, 4 or 14 makes the job fail.
- R7: If a gather-end word leaves a count or mask with payload still owed, the job fails.
- R8: A payload word whose (current class, target register) is a valid table entry is an address word. It needs a pending relocation, taken strictly in list order across gathers. That relocation must name the word's buffer, carry a byte offset equal to 4 times the word's index within its gather, and have a shift of 0. Otherwise the job fails. The index is 0 at the gather-start word and counts every word. A matching relocation is consumed.
- R9: At the job-end word, if any relocation is still unconsumed, the job fails. A job that ends with no failure raises `pass`.
- R10: A failure is sticky. Later words are still accepted and discarded. `job_start` clears `fail` and `pass`.
- R11: Table entry i is written by `tbl_we`/`tbl_idx` with a valid bit, a class and a register. An entry whose valid bit is 0 marks no register as an address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| job_start | input | 1 | Opens a job: latches class, clears verdict and relocation list |
| job_class | input | 10 | Class the job is bound to |
| cls_rng_en | input | 1 | Use the class range instead of exact class match |
| cls_lo | input | 10 | Lowest class allowed in range mode |
| cls_hi | input | 10 | Highest class allowed in range mode |
| tbl_we | input | 1 | Write one address-register table entry |
| tbl_idx | input | $clog2(TBL_N) | Entry written |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_class | input | 10 | Entry class |
| tbl_reg | input | 12 | Entry register |
| rel_we | input | 1 | Append a relocation descriptor |
| rel_buf | input | BUF_W | Buffer id the relocation points into |
| rel_off | input | OFF_W | Byte offset of the patched word |
| rel_shift | input | 5 | Address shift (must be 0) |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Word accepted (low only during `job_start`) |
| in_word | input | 32 | Command word |
| in_first | input | 1 | First word of a gather |
| in_last | input | 1 | Last word of a gather |
| in_job_last | input | 1 | Last word of the job (with `in_last`) |
| in_buf | input | BUF_W | Buffer id of the current gather |
| pass | output | 1 | Job ended clean |
| fail | output | 1 | Job rejected (sticky) |

## Verification
Two checks can fall in the same cycle: consuming the final relocation on an address payload word, and the leftover-relocation test at the job-end word. The leftover test must see the head pointer after that word's own consumption.

The bench provokes this by ending jobs on the address payload word that uses the last relocation. Such a job must pass. The same frame with one extra relocation, or with a mismatched offset, must fail.

A gather-end word that is also the last payload of a count is used the same way. It is judged against the truncation rule.

// File: rtl/cmdfw_check.sv
module cmdfw_check #(
  parameter int BUF_W = 4,
  parameter int OFF_W = 16,
  parameter int REL_N = 8,
  parameter int TBL_N = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     job_start,
  input  logic [9:0]               job_class,
  input  logic                     cls_rng_en,
  input  logic [9:0]               cls_lo,
  input  logic [9:0]               cls_hi,
  input  logic                     tbl_we,
  input  logic [$clog2(TBL_N)-1:0] tbl_idx,
  input  logic                     tbl_valid,
  input  logic [9:0]               tbl_class,
  input  logic [11:0]              tbl_reg,
  input  logic                     rel_we,
  input  logic [BUF_W-1:0]         rel_buf,
  input  logic [OFF_W-1:0]         rel_off,
  input  logic [4:0]               rel_shift,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [31:0]              in_word,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic                     in_job_last,
  input  logic [BUF_W-1:0]         in_buf,
  output logic                     pass,
  output logic                     fail
);
  localparam int RAW = $clog2(REL_N);
  localparam int RCW = RAW + 1;
  localparam int IXW = OFF_W - 2;

  typedef enum logic [1:0] {S_HDR, S_MASK, S_INC, S_FIX} st_t;

  logic [TBL_N-1:0] tv_q;
  logic [9:0]       tc_q [TBL_N];
  logic [11:0]      tr_q [TBL_N];
  logic [BUF_W-1:0] rb_q [REL_N];
  logic [OFF_W-1:0] ro_q [REL_N];
  logic [4:0]       rs_q [REL_N];
  logic [RCW-1:0]   rcnt_q, rhead_q, rhead_d;

  st_t        st_q, st_d;
  logic [11:0] reg_q, reg_d, tgt;
  logic [15:0] cnt_q, cnt_d, msk_q, msk_d;
  logic [9:0]  jcls_q, cls_q, cls_d;
  logic [IXW-1:0] widx_q, idx;
  logic fail_q, done_q, fire, live, hdr, hit, pend, rel_ok, err, jend;
  logic [3:0] op, lsb;
  logic [RAW-1:0] hp;

  assign in_ready = ~job_start;
  assign fire     = in_valid & in_ready;
  assign live     = fire & ~fail_q & ~done_q;
  assign jend     = in_last & in_job_last;
  assign idx      = in_first ? '0 : widx_q;
  assign hdr      = in_first | (st_q == S_HDR);
  assign op       = in_word[31:28];
  assign hp       = rhead_q[RAW-1:0];
  assign pend     = rhead_q < rcnt_q;
  assign rel_ok   = pend && rb_q[hp] == in_buf && ro_q[hp] == {idx, 2'b00} && rs_q[hp] == 5'd0;
  assign pass     = done_q & ~fail_q;
  assign fail     = fail_q;

  always_comb begin
    lsb = '0;
    for (int i = 15; i >= 0; i--) if (msk_q[i]) lsb = 4'(i);
  end

  assign tgt = (st_q == S_MASK) ? reg_q + 12'(lsb) : reg_q;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < TBL_N; i++)
      if (tv_q[i] && tc_q[i] == cls_q && tr_q[i] == tgt) hit = 1'b1;
  end

  always_comb begin
    st_d = st_q; reg_d = reg_q; cnt_d = cnt_q; msk_d = msk_q;
    cls_d = cls_q; rhead_d = rhead_q; err = 1'b0;
    if (hdr) begin
      st_d  = S_HDR;
      reg_d = in_word[27:16];
      cnt_d = in_word[15:0];
      msk_d = in_word[15:0];
      case (op)
        4'd0: begin
          cls_d = in_word[15:6];
          msk_d = {10'd0, in_word[5:0]};
          if (cls_rng_en ? (cls_d < cls_lo || cls_d > cls_hi) : (cls_d != jcls_q)) err = 1'b1;
          if (msk_d != 16'd0) st_d = S_MASK;
        end
        4'd1: if (cnt_d != 16'd0) st_d = S_INC;
        4'd2: if (cnt_d != 16'd0) st_d = S_FIX;
        4'd3: if (msk_d != 16'd0) st_d = S_MASK;
        4'd4, 4'd14: begin end
        default: err = 1'b1;
      endcase
    end else begin
      if (hit) begin
        if (rel_ok) rhead_d = rhead_q + 1'b1;
        else err = 1'b1;
      end
      case (st_q)
        S_MASK: begin
          msk_d = msk_q & ~(16'd1 << lsb);
          if (msk_d == 16'd0) st_d = S_HDR;
        end
        S_INC: begin
          reg_d = reg_q + 12'd1;
          cnt_d = cnt_q - 16'd1;
          if (cnt_q == 16'd1) st_d = S_HDR;
        end
        default: begin
          cnt_d = cnt_q - 16'd1;
          if (cnt_q == 16'd1) st_d = S_HDR;
        end
      endcase
    end
    if (in_last && st_d != S_HDR) err = 1'b1;
    if (jend && rhead_d != rcnt_q) err = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= '0;
      for (int i = 0; i < TBL_N; i++) begin
        tc_q[i] <= '0;
        tr_q[i] <= '0;
      end
    end else if (tbl_we) begin
      tv_q[tbl_idx] <= tbl_valid;
      tc_q[tbl_idx] <= tbl_class;
      tr_q[tbl_idx] <= tbl_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REL_N; i++) begin
        rb_q[i] <= '0;
        ro_q[i] <= '0;
        rs_q[i] <= '0;
      end
    end else if (rel_we && !job_start && !done_q && rcnt_q < RCW'(REL_N)) begin
      rb_q[rcnt_q[RAW-1:0]] <= rel_buf;
      ro_q[rcnt_q[RAW-1:0]] <= rel_off;
      rs_q[rcnt_q[RAW-1:0]] <= rel_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_HDR; reg_q <= '0; cnt_q <= '0; msk_q <= '0;
      jcls_q <= '0; cls_q <= '0; widx_q <= '0;
      rcnt_q <= '0; rhead_q <= '0; fail_q <= 1'b0; done_q <= 1'b0;
    end else if (job_start) begin
      st_q <= S_HDR; jcls_q <= job_class; cls_q <= job_class; widx_q <= '0;
      rcnt_q <= '0; rhead_q <= '0; fail_q <= 1'b0; done_q <= 1'b0;
    end else begin
      if (rel_we && !done_q && rcnt_q < RCW'(REL_N)) rcnt_q <= rcnt_q + 1'b1;
      if (live) begin
        st_q <= st_d; reg_q <= reg_d; cnt_q <= cnt_d; msk_q <= msk_d;
        cls_q <= cls_d; rhead_q <= rhead_d; widx_q <= idx + 1'b1;
        if (err) fail_q <= 1'b1;
      end
      if (fire && jend) done_q <= 1'b1;
    end
  end

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) fail_q && !job_start |=> fail_q); // R10
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n) live && hdr && op > 4'd4 && op != 4'd14 |=> fail_q); // R6
  AST_REL_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n) !job_start |=> rhead_q >= $past(rhead_q)); // R8
  AST_HEAD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) rhead_q <= rcnt_q); // R8
  AST_PASS_ALL_USED: assert property (@(posedge clk) disable iff (!rst_n) pass |-> rhead_q == rcnt_q); // R9
endmodule

// File: tb/cmdfw_check_tb_top.sv
`timescale 1ns/1ps
module cmdfw_check_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic job_start = 0, cls_rng_en = 0, tbl_we = 0, tbl_valid = 0, rel_we = 0;
  logic [9:0] job_class = 0, cls_lo = 0, cls_hi = 0, tbl_class = 0;
  logic [3:0] tbl_idx = 0, rel_buf = 0, in_buf = 0;
  logic [11:0] tbl_reg = 0;
  logic [15:0] rel_off = 0;
  logic [4:0] rel_shift = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_job_last = 0;
  logic [31:0] in_word = 0;
  logic in_ready, pass, fail;
  int nchk = 0, nfail = 0;
  localparam logic [31:0] DAT = 32'h5A5A_0000;

  always #10 clk = ~clk;

  cmdfw_check dut_i (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_class(job_class),
    .cls_rng_en(cls_rng_en), .cls_lo(cls_lo), .cls_hi(cls_hi),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_class(tbl_class), .tbl_reg(tbl_reg),
    .rel_we(rel_we), .rel_buf(rel_buf), .rel_off(rel_off), .rel_shift(rel_shift),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_first(in_first),
    .in_last(in_last), .in_job_last(in_job_last), .in_buf(in_buf), .pass(pass), .fail(fail));

  function automatic logic [31:0] hw(input logic [3:0] o, input logic [11:0] r, input logic [15:0] lo);
    return {o, r, lo};
  endfunction

  task automatic send(input logic [31:0] w, input logic f, input logic l, input logic j, input logic [3:0] b);
    @(negedge clk);
    in_valid = 1; in_word = w; in_first = f; in_last = l; in_job_last = j; in_buf = b;
    @(posedge clk); #1;
    in_valid = 0; in_first = 0; in_last = 0; in_job_last = 0;
  endtask

  task automatic new_job(input logic [9:0] c);
    @(negedge clk); job_class = c; job_start = 1;
    @(posedge clk); #1; job_start = 0;
  endtask

  task automatic add_rel(input logic [3:0] b, input logic [15:0] o, input logic [4:0] s);
    @(negedge clk); rel_we = 1; rel_buf = b; rel_off = o; rel_shift = s;
    @(posedge clk); #1; rel_we = 0;
  endtask

  task automatic set_tbl(input logic [3:0] i, input logic v, input logic [9:0] c, input logic [11:0] r);
    @(negedge clk); tbl_we = 1; tbl_idx = i; tbl_valid = v; tbl_class = c; tbl_reg = r;
    @(posedge clk); #1; tbl_we = 0;
  endtask

  task automatic verdict(input string req, input logic ep);
    nchk++;
    if (pass !== ep || fail !== ~ep) begin
      nfail++;
      $display("FAIL %s: pass=%b fail=%b expected pass=%b fail=%b", req, pass, fail, ep, ~ep);
    end
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: run incomplete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    nchk++;
    if (pass !== 0 || fail !== 0 || in_ready !== 1) begin
      nfail++;
      $display("FAIL R1: pass=%b fail=%b ready=%b expected 0 0 1", pass, fail, in_ready);
    end
    set_tbl(0, 1, 10'd5, 12'h020);

    // R3 R8 R9: incrementing write reaches address reg 0x20 at word index 3
    new_job(5); add_rel(3, 12, 0);
    send(hw(1, 12'h01E, 3), 1, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R3", 1);
    new_job(5); add_rel(3, 8, 0);
    send(hw(1, 12'h01E, 3), 1, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R8 offset", 0);

    // R4: fixed register, two address words
    new_job(5); add_rel(3, 4, 0); add_rel(3, 8, 0);
    send(hw(2, 12'h020, 2), 1, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R4", 1);
    new_job(5); add_rel(3, 4, 0);
    send(hw(2, 12'h020, 2), 1, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R8 none pending", 0);

    // R5: mask bits 0 and 4, base 0x1C -> second payload hits 0x20 at index 2
    new_job(5); add_rel(3, 8, 0);
    send(hw(3, 12'h01C, 16'h0011), 1, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R5", 1);
    new_job(5); add_rel(3, 4, 0);
    send(hw(3, 12'h01C, 16'h0011), 1, 0, 0, 3); send(DAT, 0, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R5 clear bits", 0);

    // R2: class field and range mode
    new_job(5); add_rel(3, 4, 0);
    send(hw(0, 12'h020, {10'd5, 6'd1}), 1, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R2 class match", 1);
    new_job(5);
    send(hw(0, 12'h010, {10'd6, 6'd0}), 1, 1, 1, 3);
    verdict("R2 class mismatch", 0);
    cls_rng_en = 1; cls_lo = 4; cls_hi = 7;
    new_job(5);
    send(hw(0, 12'h010, {10'd6, 6'd0}), 1, 1, 1, 3);
    verdict("R2 range in", 1);
    new_job(5);
    send(hw(0, 12'h010, {10'd9, 6'd0}), 1, 1, 1, 3);
    verdict("R2 range out", 0);
    cls_rng_en = 0;

    // R6: every opcode, zero count/mask
    for (int o = 0; o < 16; o++) begin
      new_job(0);
      send(hw(4'(o), 12'h000, 16'd0), 1, 1, 1, 0);
      verdict($sformatf("R6 op%0d", o), (o <= 4) || (o == 14));
    end

    // R7: truncation
    new_job(5);
    send(hw(1, 12'h010, 2), 1, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R7 count", 0);
    new_job(5);
    send(hw(3, 12'h010, 16'h0004), 1, 1, 1, 3);
    verdict("R7 mask", 0);
    new_job(5);
    send(hw(1, 12'h010, 0), 1, 1, 1, 3);
    verdict("R7 zero count", 1);

    // R9: leftover relocation
    new_job(5); add_rel(3, 4, 0); add_rel(3, 40, 0);
    send(hw(2, 12'h020, 1), 1, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R9 leftover", 0);

    // R10: sticky then cleared
    new_job(5);
    send(hw(5, 12'h000, 0), 1, 0, 0, 3); send(hw(4, 12'h000, 0), 0, 1, 1, 3);
    verdict("R10 sticky", 0);
    new_job(5);
    nchk++;
    if (fail !== 0 || pass !== 0) begin
      nfail++;
      $display("FAIL R10 clear: pass=%b fail=%b expected 0 0", pass, fail);
    end
    send(hw(4, 12'h000, 0), 1, 1, 1, 3);
    verdict("R10 fresh job", 1);

    // R8: two gathers, index restarts, strict order
    new_job(5); add_rel(1, 8, 0); add_rel(2, 4, 0);
    send(hw(4, 0, 0), 1, 0, 0, 1); send(hw(1, 12'h020, 1), 0, 0, 0, 1); send(DAT, 0, 1, 0, 1);
    send(hw(2, 12'h020, 1), 1, 0, 0, 2); send(DAT, 0, 1, 1, 2);
    verdict("R8 gathers", 1);
    new_job(5); add_rel(2, 4, 0); add_rel(1, 8, 0);
    send(hw(4, 0, 0), 1, 0, 0, 1); send(hw(1, 12'h020, 1), 0, 0, 0, 1); send(DAT, 0, 1, 0, 1);
    send(hw(2, 12'h020, 1), 1, 0, 0, 2); send(DAT, 0, 1, 1, 2);
    verdict("R8 order", 0);
    new_job(5); add_rel(3, 4, 2);
    send(hw(1, 12'h020, 1), 1, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R8 shift", 0);

    // R11: table entries
    set_tbl(1, 1, 10'd5, 12'h040);
    new_job(5);
    send(hw(1, 12'h040, 1), 1, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R11 entry valid", 0);
    set_tbl(1, 0, 10'd5, 12'h040);
    new_job(5);
    send(hw(1, 12'h040, 1), 1, 0, 0, 3); send(DAT, 0, 1, 1, 3);
    verdict("R11 entry invalid", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule